// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether an input or output instruction that touches a port with 1, 2 or 4 bytes may go ahead, or must end in a general-protection fault. The caller presents the machine mode (protected mode on or off, virtual-8086 mode on or off), the current and I/O privilege levels, the port number, the access width, and the cached task-segment descriptor (valid flag, type, linear base, scaled limit). Together these are one request.

When privilege already permits the access, the answer comes back at once and memory is not touched. Otherwise the checker validates the descriptor. It then fetches the bitmap offset held in the task segment. Next it fetches the 16-bit window of the permission bitmap that covers the port, and it tests one bit per byte of the access. All reads go through a single request/acknowledge port. The answer is a one-cycle completion pulse that carries allow, fault and an error flag for malformed segments.

Top module: `io_perm_check`

## Requirements
- R1: With protected mode off, or with protected mode on, virtual-8086 mode off and CPL numerically not above IOPL, the access is allowed with no memory read, and `done` is high in the cycle after the accepting edge.
- R2: When the bitmap is needed and the descriptor is not valid, or its 4-bit type is not 9, the access faults with no memory read and `err` low.
- R3: When the bitmap is needed on a valid type-9 descriptor whose scaled limit is below 103, the access faults with `err` high and no memory read; `err` is never high without `fault`.
- R4: The first read is a 2-byte read at base + 102. If the returned offset is 103 or less, the access faults with `err`. If the offset is above the scaled limit, it faults without `err`. In both cases no second read is made.
- R5: The second read is a 2-byte read at base + offset + (port >> 3), modulo 2^32.
- R6: The read word is little-endian. Bit 0 is the lowest port of the byte that `port >> 3` selects. The word is shifted right by `port & 7` and its low N bits are tested: N = 1, 2 or 4 for size code 0, 1 or 2, and size code 3 acts as 4. The access is allowed only when all N bits are 0.
- R7: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. Every cycle with both high is one transfer. `mem_req` is low whenever the block is idle.
- R8: `done` is a single-cycle pulse, and exactly one of `allow` and `fault` is high with it. `allow`, `fault` and `err` are low in every other cycle.
- R9: A request is taken only while idle, and its port, size, base and limit are captured at that edge. Later changes to those inputs, and requests made while busy, have no effect on the result and produce no extra `done`.
- R10: The synchronous active-high reset returns the block to idle, with `done`, `allow`, `fault`, `err` and `mem_req` low, including when it arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| prot_en | input | 1 | Protected mode enabled |
| v86_en | input | 1 | Virtual-8086 mode active |
| cpl | input | PL_W | Current privilege level |
| iopl | input | PL_W | I/O privilege level |
| port_addr | input | PORT_W | Port number |
| size_code | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| tss_valid | input | 1 | Cached task descriptor valid |
| tss_type | input | TYPE_W | Cached task descriptor type |
| tss_base | input | ADDR_W | Task segment linear base |
| tss_limit | input | ADDR_W | Task segment scaled limit |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | ADDR_W | Read byte address (2-byte read) |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | DATA_W | Little-endian read data |
| done | output | 1 | One-cycle completion pulse |
| allow | output | 1 | Access may proceed (with done) |
| fault | output | 1 | General-protection fault (with done) |
| err | output | 1 | Malformed task segment (with done) |

## Verification
On the privilege and descriptor fast paths, the result is due in the cycle right after the edge that takes the request. The bench samples on the first falling edge after that edge and demands `done` there. On the memory paths, `done` comes one cycle after the edge that samples the final acknowledge, so its arrival depends on the memory model's latency. For these paths the bench waits on `done` within a bounded window. It then checks the outcome, the number of reads its model served and the addresses of those reads. It also checks that `done` has fallen one cycle later.

// File: rtl/iop_pkg.sv
package iop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_READ_BASE = 2'd1,
    ST_READ_MAP  = 2'd2,
    ST_DONE      = 2'd3
  } iop_state_e;

  // task-segment type code for an available 32-bit segment
  localparam int unsigned TSS_AVAIL32   = 9;
  // byte offset of the bitmap pointer inside the segment
  localparam int unsigned MAP_PTR_OFS   = 102;
  // smallest legal limit; pointer must exceed it
  localparam int unsigned MIN_SEG_LIMIT = 103;
  // longest run of bitmap bits one access can test
  localparam int unsigned MAX_RUN       = 4;

  function automatic logic [2:0] run_length(input logic [1:0] code);
    case (code)
      2'd0:    run_length = 3'd1;
      2'd1:    run_length = 3'd2;
      default: run_length = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/iop_priv_gate.sv
module iop_priv_gate #(
  parameter int PL_W = 2
) (
  input  logic            prot_en,
  input  logic            v86_en,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] iopl,
  output logic            need_map
);
  // privilege alone suffices unless protected mode demands the bitmap
  assign need_map = prot_en && (v86_en || (cpl > iopl));
endmodule

// File: rtl/iop_desc_check.sv
module iop_desc_check
  import iop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 4
) (
  input  logic              tss_valid,
  input  logic [TYPE_W-1:0] tss_type,
  input  logic [ADDR_W-1:0] tss_limit,
  output logic              desc_bad,
  output logic              limit_short
);
  localparam logic [TYPE_W-1:0] AVAIL_TYPE = TYPE_W'(TSS_AVAIL32);
  localparam logic [ADDR_W-1:0] MIN_LIMIT  = ADDR_W'(MIN_SEG_LIMIT);

  assign desc_bad    = !tss_valid || (tss_type != AVAIL_TYPE);
  assign limit_short = tss_limit < MIN_LIMIT;
endmodule

// File: rtl/iop_window_test.sv
module iop_window_test
  import iop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word,
  input  logic [2:0]        bit_idx,
  input  logic [1:0]        size_code,
  output logic              any_set
);
  localparam int SEL_W = $clog2(DATA_W);

  logic [2:0]         run_len;
  logic [SEL_W-1:0]   first_sel;
  logic [MAX_RUN-1:0] lane;

  assign run_len   = run_length(size_code);
  assign first_sel = SEL_W'(bit_idx);

  // one lane per possible byte of the access
  for (genvar g = 0; g < MAX_RUN; g++) begin : g_lane
    localparam logic [2:0]       LANE_NUM = 3'(g);
    localparam logic [SEL_W-1:0] LANE_OFS = SEL_W'(g);
    assign lane[g] = (LANE_NUM < run_len) && word[first_sel + LANE_OFS];
  end

  assign any_set = |lane;
endmodule

// File: rtl/iop_seq.sv
module iop_seq
  import iop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              need_map,
  input  logic              desc_bad,
  input  logic              limit_short,
  input  logic [PORT_W-1:0] port_addr,
  input  logic [1:0]        size_code,
  input  logic [ADDR_W-1:0] tss_base,
  input  logic [ADDR_W-1:0] tss_limit,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              map_hit,
  output logic [2:0]        bit_idx_q,
  output logic [1:0]        size_q,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done,
  output logic              allow,
  output logic              fault,
  output logic              err,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] PTR_OFS = ADDR_W'(MAP_PTR_OFS);
  localparam logic [DATA_W-1:0] MIN_PTR = DATA_W'(MIN_SEG_LIMIT);

  iop_state_e        state_q;
  logic [PORT_W-1:0] port_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] limit_q;
  logic [ADDR_W-1:0] map_ofs;
  logic [ADDR_W-1:0] byte_sel;

  assign map_ofs   = ADDR_W'(mem_rdata);
  assign byte_sel  = ADDR_W'(port_q >> 3);
  assign bit_idx_q = port_q[2:0];
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      port_q   <= '0;
      size_q   <= '0;
      base_q   <= '0;
      limit_q  <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      allow    <= 1'b0;
      fault    <= 1'b0;
      err      <= 1'b0;
    end else begin
      done  <= 1'b0;
      allow <= 1'b0;
      fault <= 1'b0;
      err   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            port_q  <= port_addr;
            size_q  <= size_code;
            base_q  <= tss_base;
            limit_q <= tss_limit;
            if (!need_map) begin
              state_q <= ST_DONE;
              done    <= 1'b1;
              allow   <= 1'b1;
            end else if (desc_bad) begin
              state_q <= ST_DONE;
              done    <= 1'b1;
              fault   <= 1'b1;
            end else if (limit_short) begin
              state_q <= ST_DONE;
              done    <= 1'b1;
              fault   <= 1'b1;
              err     <= 1'b1;
            end else begin
              state_q  <= ST_READ_BASE;
              mem_req  <= 1'b1;
              mem_addr <= tss_base + PTR_OFS;
            end
          end
        end
        ST_READ_BASE: begin
          if (mem_ack) begin
            if (mem_rdata <= MIN_PTR) begin
              state_q <= ST_DONE;
              mem_req <= 1'b0;
              done    <= 1'b1;
              fault   <= 1'b1;
              err     <= 1'b1;
            end else if (map_ofs > limit_q) begin
              state_q <= ST_DONE;
              mem_req <= 1'b0;
              done    <= 1'b1;
              fault   <= 1'b1;
            end else begin
              state_q  <= ST_READ_MAP;
              mem_addr <= base_q + map_ofs + byte_sel;
            end
          end
        end
        ST_READ_MAP: begin
          if (mem_ack) begin
            state_q <= ST_DONE;
            mem_req <= 1'b0;
            done    <= 1'b1;
            allow   <= !map_hit;
            fault   <= map_hit;
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/io_perm_check.sv
module io_perm_check #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int DATA_W = 16,
  parameter int PL_W   = 2,
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              prot_en,
  input  logic              v86_en,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   iopl,
  input  logic [PORT_W-1:0] port_addr,
  input  logic [1:0]        size_code,
  input  logic              tss_valid,
  input  logic [TYPE_W-1:0] tss_type,
  input  logic [ADDR_W-1:0] tss_base,
  input  logic [ADDR_W-1:0] tss_limit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              allow,
  output logic              fault,
  output logic              err
);
  logic       need_map;
  logic       desc_bad;
  logic       limit_short;
  logic       map_hit;
  logic [2:0] bit_idx_q;
  logic [1:0] size_q;
  logic       busy;

  iop_priv_gate #(.PL_W(PL_W)) priv_i (
    .prot_en  (prot_en),
    .v86_en   (v86_en),
    .cpl      (cpl),
    .iopl     (iopl),
    .need_map (need_map)
  );

  iop_desc_check #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) desc_i (
    .tss_valid   (tss_valid),
    .tss_type    (tss_type),
    .tss_limit   (tss_limit),
    .desc_bad    (desc_bad),
    .limit_short (limit_short)
  );

  iop_window_test #(.DATA_W(DATA_W)) win_i (
    .word      (mem_rdata),
    .bit_idx   (bit_idx_q),
    .size_code (size_q),
    .any_set   (map_hit)
  );

  iop_seq #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .DATA_W(DATA_W)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .need_map    (need_map),
    .desc_bad    (desc_bad),
    .limit_short (limit_short),
    .port_addr   (port_addr),
    .size_code   (size_code),
    .tss_base    (tss_base),
    .tss_limit   (tss_limit),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .map_hit     (map_hit),
    .bit_idx_q   (bit_idx_q),
    .size_q      (size_q),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .done        (done),
    .allow       (allow),
    .fault       (fault),
    .err         (err),
    .busy        (busy)
  );
endmodule

// File: rtl/io_perm_check_sva.sv
module io_perm_check_sva #(
  parameter int ADDR_W = 32,
  parameter int PL_W   = 2,
  parameter int TYPE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              prot_en,
  input logic              v86_en,
  input logic [PL_W-1:0]   cpl,
  input logic [PL_W-1:0]   iopl,
  input logic              tss_valid,
  input logic [TYPE_W-1:0] tss_type,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              allow,
  input logic              fault,
  input logic              err,
  input logic              busy
);
  AST_FAST_ALLOW: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !(prot_en && (v86_en || (cpl > iopl))))
      |=> (done && allow && !mem_req)); // R1

  AST_BAD_DESC: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && prot_en && (v86_en || (cpl > iopl))
      && (!tss_valid || (tss_type != TYPE_W'(9))))
      |=> (done && fault && !err && !mem_req)); // R2

  AST_ERR_WITH_FAULT: assert property (@(posedge clk) disable iff (rst)
    err |-> (fault && done)); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R7

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({allow, fault})); // R8

  AST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!allow && !fault && !err)); // R8

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !mem_req && !busy)); // R10
endmodule

bind io_perm_check io_perm_check_sva #(
  .ADDR_W(ADDR_W), .PL_W(PL_W), .TYPE_W(TYPE_W)
) sva_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .prot_en   (prot_en),
  .v86_en    (v86_en),
  .cpl       (cpl),
  .iopl      (iopl),
  .tss_valid (tss_valid),
  .tss_type  (tss_type),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .done      (done),
  .allow     (allow),
  .fault     (fault),
  .err       (err),
  .busy      (busy)
);

// File: tb/io_perm_check_tb_top.sv
`timescale 1ns/1ps
module io_perm_check_tb_top;
  localparam int ADDR_W = 32;
  localparam int MEM_SZ = 1024;
  localparam logic [31:0] BASE = 32'h100;
  localparam int NV = 29;

  // vector: pe vm cpl iopl port size tvalid ttype limit ofs outcome reads
  // outcome: 0 allow, 1 fault, 2 fault with err
  localparam logic [64:0] VECS [NV] = '{
    {1'b0,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h200,16'h080,2'd0,2'd0},
    {1'b1,1'b0,2'd0,2'd0,16'd5,    2'd1,1'b1,4'h9,16'h200,16'h080,2'd0,2'd0},
    {1'b1,1'b0,2'd2,2'd3,16'd5,    2'd0,1'b0,4'h0,16'h200,16'h080,2'd0,2'd0},
    {1'b0,1'b1,2'd3,2'd0,16'd5,    2'd0,1'b0,4'h0,16'h200,16'h080,2'd0,2'd0},
    {1'b1,1'b1,2'd0,2'd3,16'd0,    2'd0,1'b0,4'h9,16'h200,16'h080,2'd1,2'd0},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'hB,16'h200,16'h080,2'd1,2'd0},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h060,16'h080,2'd2,2'd0},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h066,16'h080,2'd2,2'd0},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h200,16'h060,2'd2,2'd1},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h200,16'h067,2'd2,2'd1},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h067,16'h068,2'd1,2'd1},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h200,16'h201,2'd1,2'd1},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h200,16'h200,2'd0,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd0,    2'd0,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd12,   2'd0,1'b1,4'h9,16'h200,16'h080,2'd1,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd11,   2'd0,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd10,   2'd1,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd11,   2'd1,1'b1,4'h9,16'h200,16'h080,2'd1,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd9,    2'd2,1'b1,4'h9,16'h200,16'h080,2'd1,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd8,    2'd2,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd22,   2'd2,1'b1,4'h9,16'h200,16'h080,2'd1,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd21,   2'd1,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd28,   2'd2,1'b1,4'h9,16'h200,16'h080,2'd1,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd29,   2'd1,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd9,    2'd3,1'b1,4'h9,16'h200,16'h080,2'd1,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd8,    2'd3,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2},
    {1'b1,1'b1,2'd0,2'd3,16'd0,    2'd0,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'd24,   2'd0,1'b1,4'h9,16'h200,16'h080,2'd1,2'd2},
    {1'b1,1'b0,2'd3,2'd0,16'hFFFF, 2'd0,1'b1,4'h9,16'h200,16'h080,2'd0,2'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        prot_en = 1'b0;
  logic        v86_en = 1'b0;
  logic [1:0]  cpl = '0;
  logic [1:0]  iopl = '0;
  logic [15:0] port_addr = '0;
  logic [1:0]  size_code = '0;
  logic        tss_valid = 1'b0;
  logic [3:0]  tss_type = '0;
  logic [31:0] tss_base = '0;
  logic [31:0] tss_limit = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        done, allow, fault, err;

  int checks = 0;
  int errors = 0;
  int lat_cfg = 0;
  int lat_cnt;
  int reads;
  logic [31:0] addr_last, addr_prev;
  logic [7:0] mem [MEM_SZ];

  always #2.5 clk = ~clk;

  io_perm_check dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .prot_en(prot_en),
    .v86_en(v86_en), .cpl(cpl), .iopl(iopl), .port_addr(port_addr),
    .size_code(size_code), .tss_valid(tss_valid), .tss_type(tss_type),
    .tss_base(tss_base), .tss_limit(tss_limit), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .allow(allow), .fault(fault), .err(err)
  );

  // memory model: acknowledges after lat_cfg wait cycles, little-endian words
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat_cnt >= lat_cfg) begin
        mem_ack   <= 1'b1;
        mem_rdata <= {mem[(mem_addr + 32'd1) % MEM_SZ], mem[mem_addr % MEM_SZ]};
        addr_prev <= addr_last;
        addr_last <= mem_addr;
        reads     <= reads + 1;
        lat_cnt   <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] a, input logic [15:0] w);
    mem[a % MEM_SZ]           = w[7:0];
    mem[(a + 32'd1) % MEM_SZ] = w[15:8];
  endtask

  task automatic do_access(input logic pe, input logic vm, input logic [1:0] c,
                           input logic [1:0] io, input logic [15:0] pa,
                           input logic [1:0] sz, input logic tv,
                           input logic [3:0] tt, input logic [31:0] base,
                           input logic [31:0] lim, input logic [15:0] ofs,
                           input int outc, input int nrd);
    string tag;
    int cyc;
    int rd0;
    logic [31:0] exp_a1;
    logic [31:0] exp_a2;
    if (nrd == 2) tag = "R6";
    else if (nrd == 1) tag = "R4";
    else if (outc == 0) tag = "R1";
    else if (outc == 1) tag = "R2";
    else tag = "R3";
    put_word(base + 32'd102, ofs);
    exp_a1 = base + 32'd102;
    exp_a2 = base + 32'(ofs) + 32'(pa >> 3);
    @(negedge clk);
    rd0 = reads;
    prot_en = pe; v86_en = vm; cpl = c; iopl = io; port_addr = pa;
    size_code = sz; tss_valid = tv; tss_type = tt; tss_base = base;
    tss_limit = lim; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    check(done === 1'b1, tag, "done arrives", 32'(done), 32'd1);
    if (nrd == 0) check(cyc == 1, tag, "done latency", 32'(cyc), 32'd1);
    check(allow === (outc == 0), tag, "allow", 32'(allow), 32'(outc == 0));
    check(fault === (outc != 0), tag, "fault", 32'(fault), 32'(outc != 0));
    check(err === (outc == 2), tag, "err", 32'(err), 32'(outc == 2));
    check((reads - rd0) == nrd, tag, "read count", 32'(reads - rd0), 32'(nrd));
    if (nrd == 1)
      check(addr_last == exp_a1, "R4", "pointer address", addr_last, exp_a1);
    if (nrd == 2) begin
      check(addr_prev == exp_a1, "R4", "pointer address", addr_prev, exp_a1);
      check(addr_last == exp_a2, "R5", "bitmap address", addr_last, exp_a2);
    end
    @(negedge clk);
    check(!done && !allow && !fault && !err, "R8", "pulse ends",
          32'({done, allow, fault, err}), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    reads = 0;
    addr_last = '0;
    addr_prev = '0;
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'h00;
    // bitmap at BASE + 0x80: port 12, ports 24 and 31, ports 32..39 denied
    mem[32'h181] = 8'h10;
    mem[32'h183] = 8'h81;
    mem[32'h184] = 8'hFF;

    repeat (4) @(negedge clk);
    check(!done && !allow && !fault && !err && !mem_req, "R10", "reset state",
          32'({done, allow, fault, err, mem_req}), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [64:0] v;
      v = VECS[i];
      do_access(v[64], v[63], v[62:61], v[60:59], v[58:43], v[42:41], v[40],
                v[39:36], BASE, 32'(v[35:20]), v[19:4], int'(v[3:2]), int'(v[1:0]));
    end

    // R7: slow memory, request held across wait cycles
    lat_cfg = 3;
    do_access(1'b1, 1'b0, 2'd3, 2'd0, 16'd12, 2'd0, 1'b1, 4'h9, BASE, 32'h200,
              16'h080, 1, 2);
    do_access(1'b1, 1'b0, 2'd3, 2'd0, 16'd8, 2'd2, 1'b1, 4'h9, BASE, 32'h200,
              16'h080, 0, 2);
    lat_cfg = 0;

    // R5: base wraps past the top of the address space
    mem[32'h70] = 8'h00;
    do_access(1'b1, 1'b0, 2'd3, 2'd0, 16'd0, 2'd0, 1'b1, 4'h9, 32'hFFFF_FFF0,
              32'h200, 16'h080, 0, 2);

    // R9: inputs change and requests repeat while busy
    begin
      int rd0;
      int cyc;
      int extra;
      put_word(BASE + 32'd102, 16'h080);
      @(negedge clk);
      rd0 = reads;
      prot_en = 1'b1; v86_en = 1'b0; cpl = 2'd3; iopl = 2'd0;
      port_addr = 16'd12; size_code = 2'd0; tss_valid = 1'b1; tss_type = 4'h9;
      tss_base = BASE; tss_limit = 32'h200; req_valid = 1'b1;
      @(negedge clk);
      port_addr = 16'd0; tss_base = 32'h200; size_code = 2'd1;
      tss_valid = 1'b0; prot_en = 1'b0;
      cyc = 1;
      while (!done && cyc < 60) begin
        @(negedge clk);
        cyc++;
      end
      req_valid = 1'b0;
      check(done && fault && !allow, "R9", "latched result",
            32'({done, fault, allow}), 32'b110);
      check(addr_last == 32'h181, "R9", "latched bitmap address", addr_last, 32'h181);
      extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R9", "no extra done", 32'(extra), 32'd0);
      check((reads - rd0) == 2, "R9", "reads while busy", 32'(reads - rd0), 32'd2);
    end

    // R10: reset in the middle of a bitmap sequence
    @(negedge clk);
    prot_en = 1'b1; v86_en = 1'b0; cpl = 2'd3; iopl = 2'd0; port_addr = 16'd0;
    size_code = 2'd0; tss_valid = 1'b1; tss_type = 4'h9; tss_base = BASE;
    tss_limit = 32'h200; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!mem_req && !done && !fault && !allow, "R10", "mid-sequence reset",
          32'({mem_req, done, fault, allow}), 32'd0);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done || mem_req) seen++;
      end
      check(seen == 0, "R10", "stays idle after reset", 32'(seen), 32'd0);
    end
    do_access(1'b1, 1'b0, 2'd3, 2'd0, 16'd11, 2'd1, 1'b1, 4'h9, BASE, 32'h200,
              16'h080, 1, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule